// File: doc/BRIEF.md
# Serial Status Byte Streamer

This block is the slave-side responder that reports device status over a four-wire serial link using clock mode 0. The host pulls chip select low and clocks in an 8-bit command, most significant bit first, on rising clock edges. If that command matches the configured status-read code, the block starts driving its data output. It then sends an 8-bit status word, most significant bit first, with one new bit per falling clock edge. The word repeats with no gap for as long as chip select stays low and the clock keeps running.

The status word is rebuilt from live inputs at the start of every repetition. Its top bit is the ready flag (1 = idle and ready for a command, 0 = an internal operation is running). The next bit is the outcome of the latest page-against-buffer comparison (0 = identical, 1 = some bit differed). Three bits hold a configurable density pattern. The low three bits are filler with a fixed value. While the ready bit is on the line, the output tracks the ready input directly. A host that stops the clock low at that point can therefore watch for the end of a busy period without clocking more bits.

All link pins are brought into the system clock domain through synchronizers. The block finds the clock edges by oversampling. The ready and compare inputs come from the internal sequencer in the same clock domain.

Top module: `spi_stat_rd`

## Requirements
- R1: While chip select (`cs_n_i`) is high, and after reset, `so_oe_o` is 0 and `so_o` is 0.
- R2: If the 8-bit command received after chip select falls differs from `READ_OP`, the block does not drive `so_oe_o` for the rest of that frame, whatever clocking follows.
- R3: The status word is, from bit 7 down to bit 0: ready, compare-mismatch, density bits `DENS_CODE[2:0]` (default 0,0,1), and filler bits `FILL_BITS[2:0]` (default 0,0,0).
- R4: The status word leaves MSB first. Each falling SCK edge presents the next bit. The output bits 6 to 0 do not change while SCK is high.
- R5: After bit 0, the next falling edge presents bit 7 again. This continues without limit while chip select stays low.
- R6: Bits 6 to 0 are captured from the inputs at the falling edge that begins each repetition. Input changes during a repetition do not affect it but do show up in the next one.
- R7: While bit 7 is being presented, `so_o` follows `rdy_i` with one clock of delay. This includes the case where SCK is held low, so a 0 to 1 change on `rdy_i` appears on `so_o`.
- R8: The command is sampled on rising SCK edges, MSB first. A code that differs from `READ_OP` (default 8'h57) in any single bit, including the first or last, is rejected.
- R9: The first falling SCK edge after a matching command presents bit 7 and sets `so_oe_o` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the link |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select from the host, active low |
| sck_i | input | 1 | Serial clock from the host, idle low |
| si_i | input | 1 | Serial command input |
| rdy_i | input | 1 | Ready flag from the sequencer, 1 = idle |
| cmp_miss_i | input | 1 | Latest comparison result, 1 = mismatch |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Output enable for the data pad; pad is high-impedance when 0 |

## Verification
The assertions assume that each SCK level lasts several system clocks, so that every edge is seen once after synchronization. They also assume that SCK is low whenever chip select changes, and that `rdy_i` and `cmp_miss_i` are synchronous to `clk`. The bench holds every SCK phase for six system clocks and moves chip select only while SCK is low. It changes the status inputs only in the low phase of bit 3 or during a deliberate park on bit 7, so the capture point of each repetition is never ambiguous.

// File: rtl/spi_stat_pkg.sv
// Shared definitions for the serial status streamer.
// Assumes an 8-bit status word whose top bit is the ready flag.
package spi_stat_pkg;

    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_OPCODE,
        FR_STREAM,
        FR_IGNORE
    } frame_e;

    // Assemble the status word from its fields, MSB first.
    function automatic logic [STAT_W-1:0] pack_status(
        input logic       ready,
        input logic       miss,
        input logic [2:0] dens,
        input logic [2:0] fill
    );
        return {ready, miss, dens, fill};
    endfunction

endpackage

// File: rtl/spi_stat_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes STAGES >= 1; each bit is synchronized on its own (no bus coherence).
module spi_stat_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            // Shift the pin values through the chain, newest at the bottom.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/spi_stat_edge.sv
// Edge detector for a synchronized level.
// Assumes the input is already in the clk domain; outputs are one-cycle pulses.
module spi_stat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/spi_stat_cmd.sv
// Frame tracker: collects the command on rising SCK edges and decides
// whether the frame streams status or is ignored.
// Assumes no SCK rise in the first cycle after chip select goes active.
module spi_stat_cmd
    import spi_stat_pkg::*;
#(
    parameter int              OP_W    = 8,
    parameter logic [OP_W-1:0] READ_OP = 8'h57
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_act_i,
    input  logic   sck_rise_i,
    input  logic   si_i,
    output frame_e frame_o
);

    localparam int              CNT_W = $clog2(OP_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

    frame_e            st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [OP_W-2:0]   op_q;

    // Advance the frame state on chip select and command bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
            op_q  <= '0;
        end else if (!cs_act_i) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                FR_IDLE: begin
                    st_q  <= FR_OPCODE;
                    cnt_q <= '0;
                end
                FR_OPCODE: begin
                    if (sck_rise_i) begin
                        op_q <= {op_q[OP_W-3:0], si_i};
                        if (cnt_q == LAST) begin
                            st_q <= ({op_q, si_i} == READ_OP) ? FR_STREAM : FR_IGNORE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= st_q;
            endcase
        end
    end

    assign frame_o = st_q;

    // R2
    ignore_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_IGNORE) |=> (st_q != FR_STREAM));

endmodule

// File: rtl/spi_stat_shift.sv
// Status word shifter: captures the word at each repetition start and
// presents one bit per falling SCK edge; bit 7 tracks the ready input live.
// Assumes rdy_i and miss_i are synchronous to clk.
module spi_stat_shift
    import spi_stat_pkg::*;
#(
    parameter logic [2:0] DENS_CODE = 3'b001,
    parameter logic [2:0] FILL_BITS = 3'b000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stream_i,
    input  logic sck_fall_i,
    input  logic rdy_i,
    input  logic miss_i,
    output logic so_o,
    output logic so_oe_o
);

    localparam int               IDX_W = $clog2(STAT_W);
    localparam logic [IDX_W-1:0] TOP   = IDX_W'(STAT_W - 1);

    logic [STAT_W-1:0] fresh;
    logic [STAT_W-2:0] lat_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pres_q;
    logic              rdy_q;

    assign fresh = pack_status(rdy_i, miss_i, DENS_CODE, FILL_BITS);

    // Track the ready flag every cycle for the live top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= fresh[STAT_W-1];
    end

    // Capture, count and shift on falling SCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= 1'b0;
            idx_q  <= TOP;
            lat_q  <= '0;
        end else if (!stream_i) begin
            pres_q <= 1'b0;
            idx_q  <= TOP;
        end else if (sck_fall_i) begin
            if (!pres_q || idx_q == '0) begin
                pres_q <= 1'b1;
                idx_q  <= TOP;
                lat_q  <= fresh[STAT_W-2:0];
            end else begin
                idx_q <= idx_q - 1'b1;
                if (idx_q != TOP) lat_q <= {lat_q[STAT_W-3:0], 1'b0};
            end
        end
    end

    assign so_o    = pres_q & ((idx_q == TOP) ? rdy_q : lat_q[STAT_W-2]);
    assign so_oe_o = pres_q;

    // R4
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_i && pres_q && idx_q != TOP && !sck_fall_i) |=> $stable(so_o));

    // R5
    wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_i && pres_q && sck_fall_i && idx_q == '0) |=> (pres_q && idx_q == TOP));

    // R7
    live_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_i && pres_q && idx_q == TOP && !sck_fall_i) |=> (so_o == $past(rdy_i)));

endmodule

// File: rtl/spi_stat_rd.sv
// Top of the serial status streamer: synchronizes the link pins, detects
// SCK edges, decodes the command and drives the status stream.
// Assumes clock mode 0 and SCK phases several system clocks long.
module spi_stat_rd
    import spi_stat_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              OP_W        = 8,
    parameter logic [OP_W-1:0] READ_OP     = 8'h57,
    parameter logic [2:0]      DENS_CODE   = 3'b001,
    parameter logic [2:0]      FILL_BITS   = 3'b000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    input  logic rdy_i,
    input  logic cmp_miss_i,
    output logic so_o,
    output logic so_oe_o
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             cs_n_s;
    logic             sck_s;
    logic             si_s;
    logic             sck_rise;
    logic             sck_fall;
    frame_e           frame;
    logic             stream;

    spi_stat_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sck_i, si_i}),
        .q_o   (pins_s)
    );

    assign cs_n_s = pins_s[2];
    assign sck_s  = pins_s[1];
    assign si_s   = pins_s[0];

    spi_stat_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sck_s),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    spi_stat_cmd #(
        .OP_W    (OP_W),
        .READ_OP (READ_OP)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act_i   (~cs_n_s),
        .sck_rise_i (sck_rise),
        .si_i       (si_s),
        .frame_o    (frame)
    );

    assign stream = (frame == FR_STREAM);

    spi_stat_shift #(
        .DENS_CODE (DENS_CODE),
        .FILL_BITS (FILL_BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .stream_i   (stream),
        .sck_fall_i (sck_fall),
        .rdy_i      (rdy_i),
        .miss_i     (cmp_miss_i),
        .so_o       (so_o),
        .so_oe_o    (so_oe_o)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> ##1 (!so_oe_o && !so_o));

endmodule

// File: tb/spi_stat_rd_bench.sv
module spi_stat_rd_bench;

    localparam int         HP      = 6;
    localparam logic [7:0] READ_OP = 8'h57;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic rdy = 1'b1;
    logic cmp = 1'b0;
    logic so;
    logic so_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_stat_rd #(.READ_OP(READ_OP)) u_spi_stat_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sck_i      (sck),
        .si_i       (si),
        .rdy_i      (rdy),
        .cmp_miss_i (cmp),
        .so_o       (so),
        .so_oe_o    (so_oe)
    );

    function automatic logic [7:0] exp_status(input logic r, input logic c);
        return {r, c, 3'b001, 3'b000};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic start_frame();
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic send_op(input logic [7:0] op);
        for (int i = 7; i >= 0; i--) begin
            si = op[i];
            wait_clk(HP);
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    task automatic end_frame();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(HP);
        chk(so_oe, 1'b0, "R1 enable after deselect");
        chk(so, 1'b0, "R1 data after deselect");
    endtask

    // One full repetition; expected word captured at its start (R3, R5, R6).
    task automatic read_byte(input bit stir);
        logic [7:0] e;
        logic       held;
        e = exp_status(rdy, cmp);
        for (int p = 7; p >= 0; p--) begin
            wait_clk(HP);
            chk(so_oe, 1'b1, "R9 enable while streaming");
            if (p == 7) chk(so, rdy, "R7 live ready bit");
            else        chk(so, e[p], "R3 R6 status bit");
            held = so;
            if (stir && p == 3) begin
                rdy = 1'($urandom);
                cmp = 1'($urandom);
            end
            sck = 1'b1;
            wait_clk(HP);
            if (p != 7) chk(so, held, "R4 stable while SCK high");
            sck = 1'b0;
        end
    endtask

    task automatic reject_frame(input logic [7:0] op);
        start_frame();
        send_op(op);
        for (int k = 0; k < 12; k++) begin
            wait_clk(HP);
            chk(so_oe, 1'b0, "R2 R8 rejected command");
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
        end_frame();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_clk(10);
        chk(so_oe, 1'b0, "R1 enable in reset");
        rst_n = 1'b1;
        wait_clk(4);
        chk(so_oe, 1'b0, "R1 enable after reset");
        chk(so, 1'b0, "R1 data after reset");

        // Directed: ready and matched, two repetitions (R5).
        rdy = 1'b1; cmp = 1'b0;
        start_frame(); send_op(READ_OP);
        read_byte(1'b0); read_byte(1'b0);
        end_frame();

        // Directed: busy and mismatch.
        rdy = 1'b0; cmp = 1'b1;
        start_frame(); send_op(READ_OP);
        read_byte(1'b0);
        end_frame();

        // Park on bit 7 and watch ready change (R7).
        rdy = 1'b0; cmp = 1'b1;
        start_frame(); send_op(READ_OP);
        wait_clk(HP);
        chk(so, 1'b0, "R7 parked busy");
        rdy = 1'b1; wait_clk(4);
        chk(so, 1'b1, "R7 parked ready rise");
        rdy = 1'b0; wait_clk(4);
        chk(so, 1'b0, "R7 parked ready fall");
        rdy = 1'b1; wait_clk(4);
        chk(so, 1'b1, "R7 parked ready again");
        cmp = 1'b0;
        sck = 1'b1; wait_clk(HP); sck = 1'b0;
        wait_clk(HP);
        chk(so, 1'b1, "R6 bit 6 held from capture");
        end_frame();

        // Commands off by one bit or random (R2, R8).
        reject_frame(READ_OP ^ 8'h01);
        reject_frame(READ_OP ^ 8'h80);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (op == READ_OP) op = ~op;
            reject_frame(op);
        end

        // Random frames with mid-repetition input changes (R5, R6).
        for (int f = 0; f < 20; f++) begin
            rdy = 1'($urandom);
            cmp = 1'($urandom);
            start_frame(); send_op(READ_OP);
            for (int b = 0; b < 1 + int'($urandom_range(2)); b++) read_byte(1'b1);
            end_frame();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule